// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor request port and a slower memory that moves whole blocks. A request gives a byte address, a write flag and one byte of write data. The controller splits the address into three fields. The lowest bits select a byte inside a block, the middle bits select a set, and the upper bits form the tag. It looks the tag up in both ways of the selected set. The byte read of both ways runs in the same cycle as the tag compare, so a hit answers one cycle after the request is accepted.

On a miss the controller picks a way to replace. If that victim holds modified data, the whole victim block is first written back to memory. The block containing the requested byte is then fetched, installed, and its byte is returned. Writes are kept in the cache and mark the block dirty; memory sees them only when the block is evicted. A write miss allocates the block first and then merges the written byte into it. Each block carries a small saturating age counter that steers replacement toward the less recently used way.

Top module: `sa_wb_cache`

## Requirements
- R1: After reset no block is valid: the first access to any address misses, `cpuReady` is high and `memReq` is low.
- R2: When the addressed block is present, `cpuDone` and `cpuHit` are high in the cycle right after the request is accepted, `cpuRdata` holds the addressed byte, and there is no memory traffic.
- R3: On a miss a read is issued whose address is the requested address with the byte-offset bits cleared. The requested byte is returned from that block, and a later access to any byte of the same block hits.
- R4: On a miss an invalid way of the set is filled first, with way 0 before way 1. With both ways valid, the way with the larger age is evicted, and way 0 is evicted on equal ages.
- R5: Each access (hit or fill) clears the age of the way it touches and increments the age of the other way of the same set, saturating at 2^AGE_W-1.
- R6: A write hit updates only the cached byte and marks the block dirty. Memory is not accessed, and later reads return the new byte.
- R7: Evicting a dirty block first performs one memory write: the address is the victim's tag and set with offset zero, and the data is the victim's full current contents. Only then is the read issued. Evicting a clean block performs no memory write.
- R8: A write miss fetches the block, merges the written byte into it and marks it dirty, so its later eviction writes it back.
- R9: While a memory transfer is pending, `cpuReady` is low. `memReq`, `memWrite` and `memAddr` stay unchanged until the cycle in which `memAck` is high.
- R10: `cpuDone` is a single-cycle pulse. For a miss it comes in the cycle when the read is acknowledged, with `cpuHit` low.
- R11: At most one way of a set matches a given tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Request strobe, taken when `cpuReady` is high |
| cpuWrite | input | 1 | 1 = write one byte, 0 = read one byte |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | 8 | Byte to write |
| cpuReady | output | 1 | Controller idle, can take a request |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuHit | output | 1 | With `cpuDone`: 1 = served from cache |
| cpuRdata | output | 8 | Requested byte, valid with `cpuDone` |
| memReq | output | 1 | Memory transfer request, held until acknowledged |
| memWrite | output | 1 | 1 = write back a block, 0 = fetch a block |
| memAddr | output | ADDR_W | Block-aligned byte address |
| memWdata | output | 8*BLK_BYTES | Block being written back, byte 0 in the low bits |
| memAck | input | 1 | One-cycle acknowledge that completes the transfer |
| memRdata | input | 8*BLK_BYTES | Fetched block, valid with `memAck` |

## Verification
The bench builds the cache with an 8-bit address, 4-byte blocks, 4 sets and 2-bit age counters. That gives 2 offset bits, 2 index bits and a 4-bit tag. Several bytes per block let the bench check that the requested byte is picked out correctly and that a write merges into the right byte of a fetched block. With 4 sets, traffic to one set runs alongside traffic to another. Limiting most random addresses to four tag values keeps conflicts common, so age counters hit saturation and dirty evictions with write-back occur often under variable acknowledge delays.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_COMPARE   = 2'd1,
    ST_WRITEBACK = 2'd2,
    ST_FILL      = 2'd3
  } cacheState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch a new request
    logic hitCommit;  // update ages / write byte on a hit
    logic fillCommit; // install fetched block
    logic wbAddrSel;  // memory address from victim tag
    logic fillView;   // return byte from fetched block
  } ctrlStrobes_t;

endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BLK_BYTES = 2,
  parameter int SETS      = 2,
  parameter int AGE_W     = 2,
  localparam int BLK_W    = 8 * BLK_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      st,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic [7:0]        cpuWdata,
  input  logic [BLK_W-1:0]  memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [7:0]        rdByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BLK_W-1:0]  memWdata
);
  localparam int WAYS  = 2;
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [TAG_W-1:0] tagMem  [WAYS][SETS];
  logic [BLK_W-1:0] dataMem [WAYS][SETS];
  logic [AGE_W-1:0] ageMem  [WAYS][SETS];
  logic [SETS-1:0]  validMem[WAYS];
  logic [SETS-1:0]  dirtyMem[WAYS];

  logic [ADDR_W-1:0] reqAddr;
  logic              reqWrite;
  logic [7:0]        reqWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWrite <= 1'b0;
      reqWdata <= '0;
    end else if (st.capture) begin
      reqAddr  <= cpuAddr;
      reqWrite <= cpuWrite;
      reqWdata <= cpuWdata;
    end
  end

  logic [OFF_W-1:0] reqOff;
  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;
  assign reqOff = reqAddr[OFF_W-1:0];
  assign reqIdx = reqAddr[OFF_W +: IDX_W];
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]  wayHit;
  logic [BLK_W-1:0] wayBlk[WAYS];

  // lookup and data read in the same cycle
  for (genvar w = 0; w < WAYS; w++) begin : g_lookup
    assign wayHit[w] = validMem[w][reqIdx] && (tagMem[w][reqIdx] == reqTag);
    assign wayBlk[w] = dataMem[w][reqIdx];
  end

  logic hitWay;
  logic victim;
  logic accWay;
  assign hit    = |wayHit;
  assign hitWay = wayHit[1];

  always_comb begin
    if (!validMem[0][reqIdx])      victim = 1'b0;
    else if (!validMem[1][reqIdx]) victim = 1'b1;
    else                           victim = ageMem[1][reqIdx] > ageMem[0][reqIdx];
  end

  assign accWay      = st.fillCommit ? victim : hitWay;
  assign victimDirty = validMem[victim][reqIdx] && dirtyMem[victim][reqIdx];

  function automatic logic [BLK_W-1:0] mergeByte(input logic [BLK_W-1:0] blk,
                                                 input logic [OFF_W-1:0] off,
                                                 input logic [7:0] b);
    logic [BLK_W-1:0] mask;
    logic [BLK_W-1:0] ins;
    mask = {{(BLK_W-8){1'b0}}, 8'hFF} << {off, 3'b000};
    ins  = {{(BLK_W-8){1'b0}}, b} << {off, 3'b000};
    return (blk & ~mask) | ins;
  endfunction

  logic [BLK_W-1:0] baseBlk;
  logic [BLK_W-1:0] newBlk;
  logic             dataWr;
  logic             access;
  assign baseBlk = st.fillCommit ? memRdata : wayBlk[hitWay];
  assign newBlk  = reqWrite ? mergeByte(baseBlk, reqOff, reqWdata) : baseBlk;
  assign dataWr  = st.fillCommit || (st.hitCommit && reqWrite);
  assign access  = st.fillCommit || st.hitCommit;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (dataWr && accWay == 1'(w)) dataMem[w][reqIdx] <= newBlk;
      if (st.fillCommit && victim == 1'(w)) tagMem[w][reqIdx] <= reqTag;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validMem[w] <= '0;
        dirtyMem[w] <= '0;
        for (int s = 0; s < SETS; s++) ageMem[w][s] <= '0;
      end else begin
        if (st.fillCommit && victim == 1'(w)) begin
          validMem[w][reqIdx] <= 1'b1;
          dirtyMem[w][reqIdx] <= reqWrite;
        end else if (st.hitCommit && reqWrite && hitWay == 1'(w)) begin
          dirtyMem[w][reqIdx] <= 1'b1;
        end
        if (access) begin
          if (accWay == 1'(w))                     ageMem[w][reqIdx] <= '0;
          else if (ageMem[w][reqIdx] != AGE_MAX)   ageMem[w][reqIdx] <= ageMem[w][reqIdx] + 1'b1;
        end
      end
    end
  end

  logic [BLK_W-1:0] rdSrc;
  assign rdSrc    = st.fillView ? memRdata : wayBlk[hitWay];
  assign rdByte   = rdSrc[{reqOff, 3'b000} +: 8];
  assign memAddr  = {(st.wbAddrSel ? tagMem[victim][reqIdx] : reqTag), reqIdx, {OFF_W{1'b0}}};
  assign memWdata = dataMem[victim][reqIdx];

  // R11
  one_way_hit_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(wayHit));

  // R3
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rstN) st.fillCommit |=> hit);

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuValid,
  input  logic         hit,
  input  logic         victimDirty,
  input  logic         memAck,
  output ctrlStrobes_t st,
  output logic         cpuReady,
  output logic         cpuDone,
  output logic         cpuHit,
  output logic         memReq,
  output logic         memWrite
);
  cacheState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    st        = '0;
    cpuReady  = 1'b0;
    cpuDone   = 1'b0;
    cpuHit    = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuReady = 1'b1;
        if (cpuValid) begin
          st.capture = 1'b1;
          nextState  = ST_COMPARE;
        end
      end
      ST_COMPARE: begin
        if (hit) begin
          cpuDone      = 1'b1;
          cpuHit       = 1'b1;
          st.hitCommit = 1'b1;
          nextState    = ST_IDLE;
        end else if (victimDirty) begin
          nextState = ST_WRITEBACK;
        end else begin
          nextState = ST_FILL;
        end
      end
      ST_WRITEBACK: begin
        memReq       = 1'b1;
        memWrite     = 1'b1;
        st.wbAddrSel = 1'b1;
        if (memAck) nextState = ST_FILL;
      end
      ST_FILL: begin
        memReq      = 1'b1;
        st.fillView = 1'b1;
        if (memAck) begin
          st.fillCommit = 1'b1;
          cpuDone       = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN) memReq |-> !cpuReady);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWrite));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) cpuDone |=> !cpuDone);

  // R7
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWrite && memAck |=> memReq && !memWrite);

endmodule

// File: rtl/sa_wb_cache.sv
module sa_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BLK_BYTES = 2,
  parameter int SETS      = 2,
  parameter int AGE_W     = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cpuValid,
  input  logic                     cpuWrite,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [7:0]               cpuWdata,
  output logic                     cpuReady,
  output logic                     cpuDone,
  output logic                     cpuHit,
  output logic [7:0]               cpuRdata,
  output logic                     memReq,
  output logic                     memWrite,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [8*BLK_BYTES-1:0]   memWdata,
  input  logic                     memAck,
  input  logic [8*BLK_BYTES-1:0]   memRdata
);
  ctrlStrobes_t st;
  logic         hit;
  logic         victimDirty;

  cache_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuValid   (cpuValid),
    .hit        (hit),
    .victimDirty(victimDirty),
    .memAck     (memAck),
    .st         (st),
    .cpuReady   (cpuReady),
    .cpuDone    (cpuDone),
    .cpuHit     (cpuHit),
    .memReq     (memReq),
    .memWrite   (memWrite)
  );

  cache_datapath #(
    .ADDR_W   (ADDR_W),
    .BLK_BYTES(BLK_BYTES),
    .SETS     (SETS),
    .AGE_W    (AGE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .cpuAddr    (cpuAddr),
    .cpuWrite   (cpuWrite),
    .cpuWdata   (cpuWdata),
    .memRdata   (memRdata),
    .hit        (hit),
    .victimDirty(victimDirty),
    .rdByte     (cpuRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

endmodule

// File: tb/sa_wb_cache_test.sv
module sa_wb_cache_test;
  localparam int AW = 8;
  localparam int BB = 4;
  localparam int NS = 4;
  localparam int AG = 2;
  localparam int BW = 8 * BB;
  localparam int AMAX = (1 << AG) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuValid = 1'b0;
  logic          cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [7:0]    cpuWdata = '0;
  logic          cpuReady, cpuDone, cpuHit;
  logic [7:0]    cpuRdata;
  logic          memReq, memWrite;
  logic [AW-1:0] memAddr;
  logic [BW-1:0] memWdata;
  logic          memAck = 1'b0;
  logic [BW-1:0] memRdata = '0;

  sa_wb_cache #(.ADDR_W(AW), .BLK_BYTES(BB), .SETS(NS), .AGE_W(AG)) uut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuDone(cpuDone), .cpuHit(cpuHit), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  always #4 clk = ~clk; // 125 MHz

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [7:0] bmem[256]; // backing memory
  logic [7:0] gold[256]; // latest value of every byte

  // bench model of cache bookkeeping
  bit         mValid[2][NS];
  bit         mDirty[2][NS];
  int         mTag[2][NS];
  int         mAge[2][NS];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "WATCHDOG", "run timeout", cycles, 150000);
      finishRun();
    end
  end

  // memory responder: acts at falling edges with a random delay
  int waitCnt = 0;
  int delay = 1;
  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
    end else if (memReq) begin
      if (waitCnt >= delay) begin
        if (memWrite) begin
          for (int b = 0; b < BB; b++) bmem[memAddr + b] = memWdata[8*b +: 8];
        end else begin
          for (int b = 0; b < BB; b++) memRdata[8*b +: 8] = bmem[memAddr + b];
        end
        memAck  = 1'b1;
        waitCnt = 0;
        delay   = $urandom % 4;
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [7:0] wd);
    int  idx, tag, way, other, lat;
    bit  expHit, expWb, sawWb, sawRd, busyOk;
    int  wbAddr, rdAddr, expWbAddr;
    logic [BW-1:0] wbData, expWbData;
    idx = int'(addr[3:2]);
    tag = int'(addr[7:4]);
    expHit = 1'b0; way = 0;
    for (int w = 0; w < 2; w++)
      if (mValid[w][idx] && mTag[w][idx] == tag) begin expHit = 1'b1; way = w; end
    if (!expHit) begin
      if (!mValid[0][idx])      way = 0;   // R4 invalid way first
      else if (!mValid[1][idx]) way = 1;
      else                      way = (mAge[1][idx] > mAge[0][idx]) ? 1 : 0;
    end
    expWb = !expHit && mValid[way][idx] && mDirty[way][idx];
    expWbAddr = (mTag[way][idx] << 4) | (idx << 2);
    for (int b = 0; b < BB; b++) expWbData[8*b +: 8] = gold[(expWbAddr + b) & 255];

    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = addr; cpuWdata = wd;
    @(negedge clk);
    cpuValid = 1'b0;
    #1;
    if (expHit) begin
      check(cpuDone && cpuHit, "R2", "hit done one cycle after accept", {cpuDone, cpuHit}, 2'b11);
      if (!wr) check(cpuRdata == gold[addr], "R2", "hit byte", cpuRdata, gold[addr]);
      else     check(!memReq, "R6", "no memory access on write hit", memReq, 0);
    end else begin
      sawWb = 0; sawRd = 0; busyOk = 1; lat = 0; wbAddr = 0; rdAddr = 0; wbData = '0;
      check(!cpuDone, "R10", "no done in compare on miss", cpuDone, 0);
      while (!cpuDone && lat < 100) begin
        @(negedge clk); #1; lat++;
        if (memReq && cpuReady) busyOk = 0;
        if (memReq && memAck && memWrite) begin
          sawWb = 1; wbAddr = int'(memAddr); wbData = memWdata;
          if (sawRd) busyOk = 0;
        end
        if (memReq && memAck && !memWrite) begin sawRd = 1; rdAddr = int'(memAddr); end
      end
      check(cpuDone && !cpuHit, "R10", "miss done with hit low", {cpuDone, cpuHit}, 2'b10);
      check(sawRd && rdAddr == int'({addr[7:2], 2'b00}), "R3", "block-aligned fetch", rdAddr, {addr[7:2], 2'b00});
      if (!wr) check(cpuRdata == gold[addr], "R3", "miss byte", cpuRdata, gold[addr]);
      check(sawWb == expWb, "R7", "write-back occurrence", sawWb, expWb);
      if (expWb) begin
        check(wbAddr == expWbAddr, "R7", "victim address", wbAddr, expWbAddr);
        check(wbData == expWbData, "R7", "victim data", wbData, expWbData);
      end
      check(busyOk, "R9", "not ready during memory transfer", busyOk, 1);
      mValid[way][idx] = 1; mTag[way][idx] = tag; mDirty[way][idx] = 0;
    end
    if (wr) begin gold[addr] = wd; mDirty[way][idx] = 1; end  // R6 R8
    other = 1 - way;                                            // R5
    mAge[way][idx] = 0;
    if (mAge[other][idx] < AMAX) mAge[other][idx]++;
    @(negedge clk); #1;
    check(!cpuDone && cpuReady, "R10", "done is one pulse", {cpuDone, cpuReady}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < 256; a++) begin bmem[a] = 8'(a * 7 + 3); gold[a] = 8'(a * 7 + 3); end
    for (int w = 0; w < 2; w++) for (int s = 0; s < NS; s++) begin
      mValid[w][s] = 0; mDirty[w][s] = 0; mTag[w][s] = 0; mAge[w][s] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(cpuReady && !memReq && !cpuDone, "R1", "reset state", {cpuReady, memReq, cpuDone}, 3'b100);

    // directed sequence on set 0 and set 1
    access(0, 8'h01, 0);      // R1 first access misses, way 0
    access(0, 8'h02, 0);      // R3 neighbour byte hits
    access(0, 8'h13, 0);      // R4 invalid way 1 filled
    access(0, 8'h21, 0);      // R4 older way 0 evicted
    access(1, 8'h22, 8'hA5);  // R6 write hit
    access(0, 8'h22, 0);      // R6 read back
    access(0, 8'h31, 0);      // R4 clean way 1 evicted, no write-back
    access(0, 8'h00, 0);      // R7 dirty way 0 written back
    access(1, 8'h45, 8'h5A);  // R8 write miss allocates
    access(0, 8'h45, 0);      // R8 merged byte readable
    for (int i = 0; i < 5; i++) access(0, 8'h44, 0); // R5 age saturation on way 1
    access(0, 8'h54, 0);      // R5 saturated way replaced
    access(0, 8'h64, 0);      // R8 dirty block written back eventually

    // constrained random traffic
    for (int i = 0; i < 800; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 64);
      access(1'($urandom % 3 == 0), a, 8'($urandom));
    end
    finishRun();
  end
endmodule